// File: doc/BRIEF.md
# Multiphase Phase-Count Manager

This block decides how many phases of an interleaved buck controller with up to eight phases are switching at any moment. When the supply comes up, it captures a maximum phase count from one strap bit per phase and captures a low-input-voltage flag. Phases above that maximum keep their PWM outputs in high impedance until the next capture. A strap on a phase's sense input marks that phase and every phase above it as unused.

At run time a decoded power-state input selects one of three modes:

- **Full-phase** runs the captured maximum.
- **Low-phase** runs a programmed count, with separate values for cold and warm boot.
- **Auto-phase** sheds and adds phases with the load. A digitized load-current value is compared with four ascending thresholds. Each threshold has a lower release point set by a hysteresis value. The result maps onto the fixed set 1, 2, 4, 6 or 8 phases.

Auto shedding applies only when power-good is high and reference-PWM activity has been seen. A low input voltage at capture forces single-phase operation until the supply comes up again or the enable input rises with the flag clear. Every count is clamped to the captured maximum. A new count is committed only on a PWM-cycle boundary strobe, so the interleave pattern is never broken in mid-cycle.

Top module: `phase_count_mgr`

## Requirements
- R1: After reset the active count is 8, `phase_en` is 8'hFF, `phase_hiz` is 8'h00, and the captured maximum is 8.
- R2: In the cycle where `supply_ok` rises, the maximum is captured as the lowest strapped index i, where `strap[i]`=1 and phase index 0 is the first phase, with a floor of 1. With no strap set, the maximum is 8. Strap changes without a `supply_ok` rise have no effect.
- R3: Bit i of `phase_hiz` is 1 exactly when i is not below the captured maximum.
- R4: If `vin_low` is 1 when `supply_ok` rises, the committed count is 1 in every mode. This holds until a later `supply_ok` rise, or an `enable` rise, samples `vin_low`=0.
- R5: `pstate` encoding: 2'b1x selects full-phase, which uses the captured maximum. 2'b01 selects auto-phase. 2'b00 selects low-phase.
- R6: In auto-phase mode, shedding applies only while `pgood` and `ref_seen` are both 1. Otherwise the target is the captured maximum.
- R7: The shed level rises to the number of thresholds k with `load_i` >= `thr[k]`. Levels 0 to 4 give 1, 2, 4, 6 and 8 phases.
- R8: The shed level falls only to the number of thresholds k with `load_i` >= `thr[k]`-`hyst` (floored at 0). The level holds while the load is inside a hysteresis band.
- R9: In low-phase mode the target is `low_warm` when `warm_boot` is 1, and `low_cold` otherwise.
- R10: Every target is clamped to between 1 and the captured maximum. The `phase_cnt` output is also clamped to the current maximum in the cycle after a capture.
- R11: The committed count changes only at a clock edge where `cyc_strobe` is 1.
- R12: `phase_en` is a thermometer code whose bit i is 1 exactly when i < `phase_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-ready level; its rising edge captures straps and the low-voltage flag |
| enable | input | 1 | Controller enable; its rising edge re-samples the low-voltage flag |
| strap | input | 8 | Per-phase strap bits, 1 = phase and all above it unused |
| vin_low | input | 1 | Power-stage input voltage below threshold |
| pstate | input | 2 | Decoded power-state selection |
| pgood | input | 1 | Power-good status |
| ref_seen | input | 1 | Reference-PWM activity has been received |
| load_i | input | 10 | Digitized total load current |
| thr | input | 4x10 | Rising thresholds, ascending, index 0 lowest |
| hyst | input | 10 | Hysteresis subtracted to form release points |
| low_cold | input | 4 | Low-phase count for cold boot |
| low_warm | input | 4 | Low-phase count for warm boot |
| warm_boot | input | 1 | 1 = warm-boot condition |
| cyc_strobe | input | 1 | PWM-cycle boundary; count commit point |
| phase_cnt | output | 4 | Active phase count |
| phase_en | output | 8 | Per-phase enable, thermometer coded |
| phase_hiz | output | 8 | Per-phase high-impedance request |

## Verification
A strap capture and a commit strobe can land on the same clock edge. The commit then uses a target computed against the old maximum, while the new maximum takes effect at once. The bench drops and raises `supply_ok` so that the rising sample coincides with a `cyc_strobe` pulse, while running full-phase at 8 phases with straps giving a maximum of 4. In the next cycle it expects `phase_cnt` of 4, `phase_en` of 8'h0F and `phase_hiz` of 8'hF0, with no phase both enabled and in high impedance.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   typedef enum logic [1:0] {
      MODE_LOW  = 2'd0,
      MODE_AUTO = 2'd1,
      MODE_FULL = 2'd2
   } pcm_mode_e;

   // decoded power-state pattern to operating mode
   function automatic pcm_mode_e pcm_decode(input logic [1:0] ps);
      if (ps[1])
         return MODE_FULL;
      else if (ps[0])
         return MODE_AUTO;
      else
         return MODE_LOW;
   endfunction

   // shed level to phase count, fixed set 1/2/4/6/8
   function automatic int unsigned pcm_level_phases(input int unsigned lvl);
      case (lvl)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 6;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/pcm_strap_latch.sv
module pcm_strap_latch #(
   parameter int NPH = 8,
   parameter int CW  = $clog2(NPH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           supply_ok,
   input  logic           enable,
   input  logic [NPH-1:0] strap,
   input  logic           vin_low,
   output logic [CW-1:0]  max_q,
   output logic           lock_q
);

   logic          sup_d;
   logic          en_d;
   logic          sup_rise;
   logic          en_rise;
   logic [CW-1:0] strap_max;

   assign sup_rise = supply_ok & ~sup_d;
   assign en_rise  = enable & ~en_d;

   // lowest strapped index wins; no strap keeps the full width
   always_comb begin
      strap_max = CW'(NPH);
      for (int i = NPH - 1; i >= 0; i--) begin
         if (strap[i])
            strap_max = CW'(i);
      end
      if (strap_max == '0)
         strap_max = CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_d  <= 1'b0;
         en_d   <= 1'b0;
         max_q  <= CW'(NPH);
         lock_q <= 1'b0;
      end else begin
         sup_d <= supply_ok;
         en_d  <= enable;
         if (sup_rise) begin
            max_q  <= strap_max;
            lock_q <= vin_low;
         end else if (en_rise) begin
            lock_q <= vin_low;
         end
      end
   end

   // R2: without a supply rise the captured maximum holds
   a_r2_max_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_rise |=> $stable(max_q));

   // R2: the captured maximum never leaves 1..NPH
   a_r2_max_range: assert property (@(posedge clk) disable iff (!rst_n)
      (max_q >= CW'(1)) && (max_q <= CW'(NPH)));

endmodule

// File: rtl/pcm_shed_level.sv
module pcm_shed_level #(
   parameter int IW      = 10,
   parameter int NTH     = 4,
   parameter bit HYST_EN = 1'b1,
   parameter int LW      = $clog2(NTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IW-1:0]           load_i,
   input  logic [NTH-1:0][IW-1:0]  thr,
   input  logic [IW-1:0]           hyst,
   output logic [LW-1:0]           level_q
);

   logic [NTH-1:0]         up_hit;
   logic [NTH-1:0]         dn_hit;
   logic [NTH-1:0][IW-1:0] thr_fall;
   logic [LW-1:0]          up_lvl;
   logic [LW-1:0]          dn_lvl;
   logic [LW-1:0]          level_d;

   for (genvar k = 0; k < NTH; k++) begin : g_cmp
      if (HYST_EN) begin : g_hyst
         assign thr_fall[k] = (thr[k] > hyst) ? (thr[k] - hyst) : '0;
      end else begin : g_nohyst
         assign thr_fall[k] = thr[k];
      end
      assign up_hit[k] = (load_i >= thr[k]);
      assign dn_hit[k] = (load_i >= thr_fall[k]);
   end

   always_comb begin
      up_lvl = '0;
      dn_lvl = '0;
      for (int k = 0; k < NTH; k++) begin
         up_lvl = up_lvl + LW'(up_hit[k]);
         dn_lvl = dn_lvl + LW'(dn_hit[k]);
      end
      if (up_lvl > level_q)
         level_d = up_lvl;
      else if (dn_lvl < level_q)
         level_d = dn_lvl;
      else
         level_d = level_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level_q <= '0;
      else
         level_d_apply: level_q <= level_d;
   end

   // R7: load above every rising threshold reaches the top level
   a_r7_top_level: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i >= thr[NTH-1]) |=> (level_q == LW'(NTH)));

   // R8: load below every release point returns to level 0
   a_r8_floor_level: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_hit == '0) |=> (level_q == '0));

   // R7: level stays within the threshold count
   a_r7_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LW'(NTH));

endmodule

// File: rtl/pcm_count_sel.sv
module pcm_count_sel
   import pcm_pkg::*;
#(
   parameter int NPH = 8,
   parameter int CW  = $clog2(NPH + 1),
   parameter int LW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CW-1:0]  max_q,
   input  logic           lock,
   input  logic [1:0]     pstate,
   input  logic           pgood,
   input  logic           ref_seen,
   input  logic [LW-1:0]  level,
   input  logic [CW-1:0]  low_cold,
   input  logic [CW-1:0]  low_warm,
   input  logic           warm_boot,
   input  logic           cyc_strobe,
   output logic [CW-1:0]  phase_cnt,
   output logic [NPH-1:0] phase_en,
   output logic [NPH-1:0] phase_hiz
);

   pcm_mode_e     mode;
   int unsigned   raw;
   logic [CW-1:0] target;
   logic [CW-1:0] cnt_q;

   assign mode = pcm_decode(pstate);

   always_comb begin
      raw = 32'(max_q);
      if (lock) begin
         raw = 1;
      end else begin
         case (mode)
            MODE_AUTO: raw = (pgood && ref_seen) ?
                             pcm_level_phases(32'(level)) : 32'(max_q);
            MODE_LOW:  raw = warm_boot ? 32'(low_warm) : 32'(low_cold);
            default:   raw = 32'(max_q);
         endcase
      end
      if (raw == 0)
         raw = 1;
      if (raw > 32'(max_q))
         raw = 32'(max_q);
      target = CW'(raw);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CW'(NPH);
      else if (cyc_strobe)
         cnt_q <= target;
   end

   assign phase_cnt = (cnt_q > max_q) ? max_q : cnt_q;

   for (genvar i = 0; i < NPH; i++) begin : g_phase
      assign phase_en[i]  = (CW'(i) < phase_cnt);
      assign phase_hiz[i] = (CW'(i) >= max_q);
   end

   // R11: committed count is held between strobes
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_strobe |=> $stable(cnt_q));

   // R12: enable vector is a thermometer code
   a_r12_therm: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_en + NPH'(1)) & phase_en) == '0);

   // R12: enabled phases match the reported count
   a_r12_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_en) == 32'(phase_cnt));

   // R3: no phase is both enabled and high impedance
   a_r3_hiz_off: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_en & phase_hiz) == '0);

   // R4: a locked commit yields single phase
   a_r4_lock_single: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && cyc_strobe) |=> (phase_cnt == CW'(1)));

endmodule

// File: rtl/phase_count_mgr.sv
module phase_count_mgr
   import pcm_pkg::*;
#(
   parameter int NPH     = 8,
   parameter int IW      = 10,
   parameter int NTH     = 4,
   parameter bit HYST_EN = 1'b1,
   localparam int CW     = $clog2(NPH + 1),
   localparam int LW     = $clog2(NTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    supply_ok,
   input  logic                    enable,
   input  logic [NPH-1:0]          strap,
   input  logic                    vin_low,
   input  logic [1:0]              pstate,
   input  logic                    pgood,
   input  logic                    ref_seen,
   input  logic [IW-1:0]           load_i,
   input  logic [NTH-1:0][IW-1:0]  thr,
   input  logic [IW-1:0]           hyst,
   input  logic [CW-1:0]           low_cold,
   input  logic [CW-1:0]           low_warm,
   input  logic                    warm_boot,
   input  logic                    cyc_strobe,
   output logic [CW-1:0]           phase_cnt,
   output logic [NPH-1:0]          phase_en,
   output logic [NPH-1:0]          phase_hiz
);

   if (NPH < 2 || NPH > 16) begin : g_bad_nph
      $error("phase_count_mgr: NPH must be 2..16");
   end
   if (NTH != 4) begin : g_bad_nth
      $error("phase_count_mgr: shed map needs exactly 4 thresholds");
   end
   if (IW < 2) begin : g_bad_iw
      $error("phase_count_mgr: IW too small");
   end

   logic [CW-1:0] max_q;
   logic          lock_q;
   logic [LW-1:0] level_q;

   pcm_strap_latch #(.NPH(NPH), .CW(CW)) u_strap (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .enable    (enable),
      .strap     (strap),
      .vin_low   (vin_low),
      .max_q     (max_q),
      .lock_q    (lock_q)
   );

   pcm_shed_level #(.IW(IW), .NTH(NTH), .HYST_EN(HYST_EN), .LW(LW)) u_shed (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .thr     (thr),
      .hyst    (hyst),
      .level_q (level_q)
   );

   pcm_count_sel #(.NPH(NPH), .CW(CW), .LW(LW)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .max_q      (max_q),
      .lock       (lock_q),
      .pstate     (pstate),
      .pgood      (pgood),
      .ref_seen   (ref_seen),
      .level      (level_q),
      .low_cold   (low_cold),
      .low_warm   (low_warm),
      .warm_boot  (warm_boot),
      .cyc_strobe (cyc_strobe),
      .phase_cnt  (phase_cnt),
      .phase_en   (phase_en),
      .phase_hiz  (phase_hiz)
   );

   // R10: reported count never exceeds the captured maximum
   a_r10_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_cnt <= max_q) && (phase_cnt >= CW'(1)));

endmodule

// File: tb/phase_count_mgr_bench.sv
module phase_count_mgr_bench;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            supply_ok = 1'b0;
   logic            enable = 1'b0;
   logic [7:0]      strap = '0;
   logic            vin_low = 1'b0;
   logic [1:0]      pstate = 2'b10;
   logic            pgood = 1'b0;
   logic            ref_seen = 1'b0;
   logic [9:0]      load_i = '0;
   logic [3:0][9:0] thr;
   logic [9:0]      hyst = 10'd20;
   logic [3:0]      low_cold = 4'd3;
   logic [3:0]      low_warm = 4'd5;
   logic            warm_boot = 1'b0;
   logic            cyc_strobe = 1'b0;
   logic [3:0]      phase_cnt;
   logic [7:0]      phase_en;
   logic [7:0]      phase_hiz;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   phase_count_mgr u_phase_count_mgr (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
      .strap(strap), .vin_low(vin_low), .pstate(pstate), .pgood(pgood),
      .ref_seen(ref_seen), .load_i(load_i), .thr(thr), .hyst(hyst),
      .low_cold(low_cold), .low_warm(low_warm), .warm_boot(warm_boot),
      .cyc_strobe(cyc_strobe), .phase_cnt(phase_cnt), .phase_en(phase_en),
      .phase_hiz(phase_hiz)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int therm(input int n);
      return (1 << n) - 1;
   endfunction

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic commit();
      cyc_strobe = 1'b1;
      @(negedge clk);
      cyc_strobe = 1'b0;
   endtask

   task automatic supply_cycle(input logic [7:0] s, input logic vl);
      supply_ok = 1'b0;
      @(negedge clk);
      strap = s;
      vin_low = vl;
      supply_ok = 1'b1;
      @(negedge clk);
   endtask

   task automatic expect_cnt(input string tag, input int n, input int mx);
      chk({tag, " cnt"}, phase_cnt, n);
      chk({tag, " en"}, phase_en, therm(n));
      chk({tag, " hiz"}, phase_hiz, 8'hFF & ~therm(mx));
   endtask

   task automatic t_reset();
      expect_cnt("R1 reset", 8, 8);
   endtask

   task automatic t_strap();
      supply_cycle(8'h80, 1'b0);
      expect_cnt("R2 R3 strap7", 7, 7);
      strap = 8'h00;
      wait_n(3);
      chk("R2 strap ignored hiz", phase_hiz, 8'h80);
      supply_cycle(8'h00, 1'b0);
      expect_cnt("R2 no strap", 8, 8);
      supply_cycle(8'h01, 1'b0);
      chk("R2 floor max1 hiz", phase_hiz, 8'hFE);
      chk("R10 floor cnt", phase_cnt, 1);
      supply_cycle(8'h00, 1'b0);
      pstate = 2'b10;
      commit();
      expect_cnt("R5 full", 8, 8);
   endtask

   task automatic t_low();
      pstate = 2'b00;
      warm_boot = 1'b0;
      low_cold = 4'd3;
      wait_n(3);
      chk("R11 no strobe", phase_cnt, 8);
      commit();
      expect_cnt("R9 cold", 3, 8);
      warm_boot = 1'b1;
      low_warm = 4'd5;
      commit();
      expect_cnt("R9 warm", 5, 8);
      low_warm = 4'd0;
      commit();
      chk("R10 zero to one", phase_cnt, 1);
      low_warm = 4'd12;
      commit();
      chk("R10 clamp low", phase_cnt, 8);
   endtask

   task automatic load_step(input int ld, input int exp, input string tag);
      load_i = 10'(ld);
      @(negedge clk);
      commit();
      expect_cnt(tag, exp, 8);
   endtask

   task automatic t_auto();
      pstate = 2'b01;
      pgood = 1'b0;
      ref_seen = 1'b1;
      load_step(50, 8, "R6 no pgood");
      pgood = 1'b1;
      ref_seen = 1'b0;
      load_step(50, 8, "R6 no ref");
      ref_seen = 1'b1;
      load_step(50, 1, "R7 lvl0");
      load_step(150, 2, "R7 lvl1");
      load_step(250, 4, "R7 lvl2");
      load_step(350, 6, "R7 lvl3");
      load_step(450, 8, "R7 lvl4");
      load_step(390, 8, "R8 band hold");
      load_step(370, 6, "R8 release3");
      load_step(290, 6, "R8 band hold2");
      load_step(270, 4, "R8 release2");
      load_step(300, 6, "R7 equal rises");
      load_step(0, 1, "R8 floor");
   endtask

   task automatic t_clamp_auto();
      supply_cycle(8'h20, 1'b0);
      load_i = 10'd450;
      @(negedge clk);
      commit();
      expect_cnt("R10 auto clamp", 5, 5);
   endtask

   task automatic t_lowvin();
      supply_cycle(8'h00, 1'b1);
      pstate = 2'b10;
      commit();
      expect_cnt("R4 locked full", 1, 8);
      enable = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      commit();
      chk("R4 still locked", phase_cnt, 1);
      vin_low = 1'b0;
      enable = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      commit();
      expect_cnt("R4 released", 8, 8);
   endtask

   task automatic t_coincide();
      pstate = 2'b11;
      commit();
      chk("R5 pstate 11 full", phase_cnt, 8);
      supply_ok = 1'b0;
      @(negedge clk);
      strap = 8'h10;
      supply_ok = 1'b1;
      cyc_strobe = 1'b1;
      @(negedge clk);
      cyc_strobe = 1'b0;
      expect_cnt("R10 R2 coincide", 4, 4);
      commit();
      expect_cnt("R10 after coincide", 4, 4);
   endtask

   initial begin
      thr[0] = 10'd100;
      thr[1] = 10'd200;
      thr[2] = 10'd300;
      thr[3] = 10'd400;
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      enable = 1'b1;
      @(negedge clk);
      t_strap();
      t_low();
      t_auto();
      t_clamp_auto();
      supply_cycle(8'h00, 1'b0);
      t_lowvin();
      t_coincide();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule